// File: doc/BRIEF.md
# Serial Flash Identification Responder

This block is the device-side logic that answers the two identification commands of a serial flash slave. While chip select is low it gathers an opcode from the serial input, MSB first, on rising serial-clock edges. It then either sends a multi-byte identity that wraps around, or waits out three dummy bytes and sends a one-byte device code over and over. Output bits change on falling serial-clock edges. Raising chip select ends the exchange and releases the output.

The serial pins are oversampled by the chip's system clock. A short synchronizer feeds edge detectors, a command sequencer and an output shifter. The serial output is given as a data bit plus an output enable, and the pad logic outside builds the tri-state driver. A write-busy input from the rest of the flash makes the block refuse an identification command whose opcode completes while a write is running.

Top module: `spi_id_responder`

## Requirements
- R1: After reset, and for as long as cs_n is high whatever sck does, so_oe is 0.
- R2: Opcode 8'h9F sends the bytes 8'h62, 8'h16, 8'h13, 8'h00 in that order, each MSB first. The first bit (bit 7 of 8'h62) appears on the first falling sck edge after the eighth rising edge.
- R3: After its fourth byte the identity wraps to 8'h62 and repeats for as long as sck keeps toggling with cs_n low.
- R4: Opcode 8'hAB is followed by 24 dummy bits whose values are ignored. The device code 8'h3E then starts, MSB first, at the first falling edge after the 32nd rising edge.
- R5: After the device code has been sent once, the same byte 8'h3E is sent again for every further eight clocks.
- R6: so_oe stays 0 during the opcode and dummy bits and goes to 1 with the first output bit. Once set, it stays set until cs_n rises.
- R7: If write_busy is 1 when the eighth opcode bit is sampled, the command is refused and so_oe stays 0 until cs_n rises.
- R8: Any opcode other than 8'h9F or 8'hAB leaves so_oe at 0 for the whole cs_n-low period.
- R9: A rising cs_n drives so_oe to 0 within SYNC_STAGES+2 system clocks. The next cs_n-low period starts a fresh opcode.
- R10: The behaviour is the same whether sck idles low (mode 0) or high (mode 3) when cs_n falls.
- R11: so_data changes only after a falling sck edge, and it holds across the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| write_busy | input | 1 | High while an internal write operation runs |
| so_data | output | 1 | Serial output data bit |
| so_oe | output | 1 | Output enable for the serial output pad |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, three dummy bytes, a four-byte identity and the codes given above. The host clock has a half period of eight system clocks. This leaves time to check each output bit both before and after the rising edge. Transactions of up to six output bytes show the identity wrapping past its fourth byte and the device code repeating. The full 24 dummy bits are carried with random values. Random transactions mix both clock modes, busy refusals and unknown opcodes, and each one follows right after another, so stale state would surface.

// File: rtl/spi_id_pkg.sv
package spi_id_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_OPC   = 3'd0,
        ST_DUMMY = 3'd1,
        ST_IDENT = 3'd2,
        ST_CODE  = 3'd3,
        ST_MUTE  = 3'd4
    } seq_st_e;

    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_IDENT = 2'd1,
        OUT_CODE  = 2'd2
    } out_sel_e;

endpackage

// File: rtl/idr_sync.sv
module idr_sync #(
    parameter int              WIDTH    = 3,
    parameter int              STAGES   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0,
    parameter int              EDGE_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] sync_o,
    output logic             rise_o,
    output logic             fall_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
        logic                         prev;
    } sync_s;

    sync_s s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stg[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            s_d.stg[i] = s_q.stg[i-1];
        end
        s_d.prev = s_q.stg[STAGES-1][EDGE_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                s_q.stg[i] <= RST_VAL;
            end
            s_q.prev <= RST_VAL[EDGE_BIT];
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o = s_q.stg[STAGES-1];
    assign rise_o = s_q.stg[STAGES-1][EDGE_BIT] & ~s_q.prev;
    assign fall_o = ~s_q.stg[STAGES-1][EDGE_BIT] & s_q.prev;

endmodule

// File: rtl/idr_seq.sv
module idr_seq
    import spi_id_pkg::*;
#(
    parameter int               DUMMY_BYTES = 3,
    parameter logic [BYTE_W-1:0] IDENT_OP   = 8'h9F,
    parameter logic [BYTE_W-1:0] CODE_OP    = 8'hAB
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_act,
    input  logic     rise,
    input  logic     si_s,
    input  logic     busy,
    output out_sel_e out_sel
);

    localparam int DUMMY_BITS = DUMMY_BYTES * BYTE_W;
    localparam int DCW        = $clog2(DUMMY_BITS + 1);
    localparam logic [DCW-1:0] DLAST = DCW'(DUMMY_BITS - 1);
    localparam int BCW        = $clog2(BYTE_W);

    typedef struct packed {
        seq_st_e           st;
        logic [BCW-1:0]    bit_cnt;
        logic [DCW-1:0]    dcnt;
        logic [BYTE_W-2:0] opc;
    } seq_s;

    seq_s q_d, q_q;
    logic [BYTE_W-1:0] full_op;

    assign full_op = {q_q.opc, si_s};

    always_comb begin
        q_d = q_q;
        if (!cs_act) begin
            q_d.st      = ST_OPC;
            q_d.bit_cnt = '0;
            q_d.dcnt    = '0;
            q_d.opc     = '0;
        end else if (rise) begin
            case (q_q.st)
                ST_OPC: begin
                    q_d.opc     = full_op[BYTE_W-2:0];
                    q_d.bit_cnt = q_q.bit_cnt + 1'b1;
                    if (q_q.bit_cnt == BCW'(BYTE_W - 1)) begin
                        if (busy) begin
                            q_d.st = ST_MUTE;
                        end else if (full_op == IDENT_OP) begin
                            q_d.st = ST_IDENT;
                        end else if (full_op == CODE_OP) begin
                            q_d.st = ST_DUMMY;
                        end else begin
                            q_d.st = ST_MUTE;
                        end
                    end
                end
                ST_DUMMY: begin
                    q_d.dcnt = q_q.dcnt + 1'b1;
                    if (q_q.dcnt == DLAST) begin
                        q_d.st = ST_CODE;
                    end
                end
                default: q_d = q_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{st: ST_OPC, bit_cnt: '0, dcnt: '0, opc: '0};
        end else begin
            q_q <= q_d;
        end
    end

    always_comb begin
        case (q_q.st)
            ST_IDENT: out_sel = OUT_IDENT;
            ST_CODE:  out_sel = OUT_CODE;
            default:  out_sel = OUT_NONE;
        endcase
    end

    // R4: the dummy counter never runs past the dummy window
    p_dummy_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == ST_DUMMY) |-> (q_q.dcnt < DCW'(DUMMY_BITS)));

    // R7: a completed opcode seen while busy is refused
    p_busy_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && rise && q_q.st == ST_OPC && q_q.bit_cnt == BCW'(BYTE_W - 1) && busy)
        |=> (q_q.st == ST_MUTE));

    // R8: a refused command stays refused while select is held
    p_mute_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == ST_MUTE && cs_act) |=> (q_q.st == ST_MUTE));

    // R9: deselect returns the sequencer to opcode collection
    p_desel_fresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (q_q.st == ST_OPC && q_q.bit_cnt == '0));

endmodule

// File: rtl/idr_shift.sv
module idr_shift
    import spi_id_pkg::*;
#(
    parameter int                        ID_BYTES = 4,
    parameter logic [ID_BYTES*BYTE_W-1:0] IDENT   = 32'h6216_1300,
    parameter logic [BYTE_W-1:0]          CODE    = 8'h3E
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_act,
    input  logic     fall,
    input  out_sel_e out_sel,
    output logic     so_data,
    output logic     so_oe
);

    localparam int IBW = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;
    localparam int BCW = $clog2(BYTE_W);
    localparam logic [IBW-1:0] ILAST = IBW'(ID_BYTES - 1);

    typedef struct packed {
        logic           data;
        logic           oe;
        logic [BCW-1:0] bit_idx;
        logic [IBW-1:0] byte_idx;
    } shf_s;

    shf_s q_d, q_q;
    logic [BYTE_W-1:0] id_arr [ID_BYTES];
    logic [BYTE_W-1:0] cur_byte;

    for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
        assign id_arr[g] = IDENT[(ID_BYTES-1-g)*BYTE_W +: BYTE_W];
    end

    assign cur_byte = (out_sel == OUT_IDENT) ? id_arr[q_q.byte_idx] : CODE;

    always_comb begin
        q_d = q_q;
        if (!cs_act) begin
            q_d.data     = 1'b0;
            q_d.oe       = 1'b0;
            q_d.bit_idx  = BCW'(BYTE_W - 1);
            q_d.byte_idx = '0;
        end else if (fall && out_sel != OUT_NONE) begin
            q_d.oe      = 1'b1;
            q_d.data    = cur_byte[q_q.bit_idx];
            q_d.bit_idx = q_q.bit_idx - 1'b1;
            if (q_q.bit_idx == '0) begin
                q_d.byte_idx = (q_q.byte_idx == ILAST) ? '0 : q_q.byte_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{data: 1'b0, oe: 1'b0, bit_idx: BCW'(BYTE_W - 1), byte_idx: '0};
        end else begin
            q_q <= q_d;
        end
    end

    assign so_data = q_q.data;
    assign so_oe   = q_q.oe;

    // R11: output data moves only on a detected falling edge
    p_data_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && !fall) |=> $stable(so_data));

    // R9: deselect releases the output
    p_oe_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !so_oe);

    // R8: no selected source, no enable
    p_quiet_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == OUT_NONE && !so_oe) |=> !so_oe);

    // R6: once driving, the output keeps driving until deselect
    p_oe_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && cs_act) |=> so_oe);

endmodule

// File: rtl/spi_id_responder.sv
module spi_id_responder
    import spi_id_pkg::*;
#(
    parameter int                        SYNC_STAGES = 2,
    parameter int                        DUMMY_BYTES = 3,
    parameter int                        ID_BYTES    = 4,
    parameter logic [BYTE_W-1:0]          IDENT_OP   = 8'h9F,
    parameter logic [BYTE_W-1:0]          CODE_OP    = 8'hAB,
    parameter logic [ID_BYTES*BYTE_W-1:0] IDENT      = 32'h6216_1300,
    parameter logic [BYTE_W-1:0]          CODE       = 8'h3E
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic write_busy,
    output logic so_data,
    output logic so_oe
);

    localparam int PIN_W   = 3;
    localparam int CS_BIT  = 2;
    localparam int SCK_BIT = 1;
    localparam int SI_BIT  = 0;

    logic [PIN_W-1:0] pins_s;
    logic             sck_rise, sck_fall;
    logic             cs_act;
    out_sel_e         out_sel;

    idr_sync #(
        .WIDTH    (PIN_W),
        .STAGES   (SYNC_STAGES),
        .RST_VAL  (3'b100),
        .EDGE_BIT (SCK_BIT)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    ({cs_n, sck, si}),
        .sync_o (pins_s),
        .rise_o (sck_rise),
        .fall_o (sck_fall)
    );

    assign cs_act = ~pins_s[CS_BIT];

    idr_seq #(
        .DUMMY_BYTES (DUMMY_BYTES),
        .IDENT_OP    (IDENT_OP),
        .CODE_OP     (CODE_OP)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_act  (cs_act),
        .rise    (sck_rise),
        .si_s    (pins_s[SI_BIT]),
        .busy    (write_busy),
        .out_sel (out_sel)
    );

    idr_shift #(
        .ID_BYTES (ID_BYTES),
        .IDENT    (IDENT),
        .CODE     (CODE)
    ) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_act  (cs_act),
        .fall    (sck_fall),
        .out_sel (out_sel),
        .so_data (so_data),
        .so_oe   (so_oe)
    );

endmodule

// File: tb/spi_id_responder_tb.sv
module spi_id_responder_tb_top;

    localparam int HALF = 8;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic write_busy = 1'b0;
    logic so_data, so_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    spi_id_responder dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sck        (sck),
        .si         (si),
        .write_busy (write_busy),
        .so_data    (so_data),
        .so_oe      (so_oe)
    );

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // kind: 0 = no output, 1 = identity, 2 = device code
    function automatic logic exp_bit(input int kind, input int bi, input int k);
        logic [7:0] b;
        if (kind == 1) begin
            case (bi % 4)
                0:       b = 8'h62;
                1:       b = 8'h16;
                2:       b = 8'h13;
                default: b = 8'h00;
            endcase
        end else begin
            b = 8'h3E;
        end
        return b[7-k];
    endfunction

    function automatic string out_tag(input int kind, input bit busy, input int bi);
        if (kind == 1) return (bi < 4) ? "R2" : "R3";
        if (kind == 2) return (bi == 0) ? "R4" : "R5";
        return busy ? "R7" : "R8";
    endfunction

    task automatic run_txn(input bit mode3, input logic [7:0] opc,
                           input int n_out, input bit busy);
        int    kind;
        int    n_dummy;
        string pre;
        pre     = mode3 ? "R10/" : "";
        n_dummy = (opc == 8'hAB) ? 24 : 0;
        kind    = busy ? 0 : (opc == 8'h9F) ? 1 : (opc == 8'hAB) ? 2 : 0;
        write_busy = busy;
        sck = mode3;
        ticks(4);
        cs_n = 1'b0;
        ticks(4);
        for (int i = 0; i < 8; i++) begin
            sck = 1'b0;
            si  = opc[7-i];
            ticks(HALF);
            chk({pre, "R6 opcode phase so_oe"}, so_oe, 1'b0);
            sck = 1'b1;
            ticks(HALF);
        end
        for (int i = 0; i < n_dummy; i++) begin
            sck = 1'b0;
            si  = 1'($urandom);
            ticks(HALF);
            chk({pre, "R4 dummy phase so_oe"}, so_oe, 1'b0);
            sck = 1'b1;
            ticks(HALF);
        end
        for (int b = 0; b < n_out; b++) begin
            for (int k = 0; k < 8; k++) begin
                sck = 1'b0;
                si  = 1'($urandom);
                ticks(HALF - 1);
                if (kind == 0) begin
                    chk({pre, out_tag(kind, busy, b), " refused so_oe"}, so_oe, 1'b0);
                end else begin
                    chk({pre, "R6 output so_oe"}, so_oe, 1'b1);
                    chk({pre, out_tag(kind, busy, b), " so_data"}, so_data, exp_bit(kind, b, k));
                end
                ticks(1);
                sck = 1'b1;
                ticks(HALF / 2);
                if (kind != 0) begin
                    chk({pre, "R11 so_data held over rising edge"}, so_data, exp_bit(kind, b, k));
                end
                ticks(HALF - HALF / 2);
            end
        end
        if (!mode3) sck = 1'b0;
        ticks(HALF);
        cs_n = 1'b1;
        ticks(SYNC + 3);
        chk({pre, "R9 so_oe after deselect"}, so_oe, 1'b0);
        write_busy = 1'b0;
        ticks(HALF);
    endtask

    initial begin
        logic [7:0] opc;
        int         r;
        void'($urandom(32'h0000_51D5));
        ticks(5);
        chk("R1 so_oe in reset", so_oe, 1'b0);
        rst_n = 1'b1;
        ticks(4);
        chk("R1 so_oe after reset", so_oe, 1'b0);
        for (int i = 0; i < 6; i++) begin
            sck = ~sck;
            si  = 1'($urandom);
            ticks(HALF);
            chk("R1 so_oe while deselected", so_oe, 1'b0);
        end
        sck = 1'b0;
        ticks(HALF);

        run_txn(1'b0, 8'h9F, 6, 1'b0);
        run_txn(1'b1, 8'h9F, 5, 1'b0);
        run_txn(1'b0, 8'hAB, 3, 1'b0);
        run_txn(1'b1, 8'hAB, 2, 1'b0);
        run_txn(1'b0, 8'h9F, 2, 1'b1);
        run_txn(1'b1, 8'hAB, 2, 1'b1);
        run_txn(1'b0, 8'h05, 2, 1'b0);
        run_txn(1'b1, 8'h9E, 1, 1'b0);
        run_txn(1'b0, 8'hAA, 1, 1'b0);
        run_txn(1'b0, 8'h9F, 1, 1'b0);

        for (int t = 0; t < 30; t++) begin
            r = int'($urandom % 5);
            case (r)
                0, 1: opc = 8'h9F;
                2:    opc = 8'hAB;
                3: begin
                    opc = 8'($urandom);
                    if (opc == 8'h9F || opc == 8'hAB) opc = 8'h00;
                end
                default: opc = ($urandom % 2 == 0) ? 8'h9F : 8'hAB;
            endcase
            run_txn(1'($urandom), opc, 1 + int'($urandom % 6), (r == 4));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog run for all requirements actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule